// File: doc/BRIEF.md
# Narrow-Block Substitution-Mixing Cipher Core

This core encrypts or decrypts a single 32-bit or 64-bit value. A parameter fixes the width. Each round works on 32-bit columns on their own. It applies the AES byte substitution to every byte, then the AES column-mixing matrix to each column, then XORs a block-wide round subkey. No bytes move between columns inside a round. In the 64-bit build, bytes are traded between the two words at the start of every round, so that the whole block is diffused.

The surrounding logic holds the subkeys. The core asks for them one at a time. It drives a round index, and the subkey for that index must come back combinationally in the same cycle. A one-cycle `start` launches an operation, and `encrypt` selects its direction. One round completes per clock. `done` pulses once when the result is on `dout`, and the result stays there until the next launch. Expanding a master key into subkeys is left to the surrounding logic.

Top module: `sbc_core`

## Requirements
- R1: A synchronous active-high reset clears `done` to 0, leaves the core idle and clears `dout` to zero.
- R2: A `start` seen while idle captures `din` and the direction. Exactly `ROUNDS` clock edges later, `done` goes high for a single cycle.
- R3: A full encryption round is applied to each 32-bit column `c = s[32k+31:32k]`, where byte 0 of the column is bits [7:0]. The S-box is applied to every byte. Then output byte i = 2·b(i) ⊕ 3·b(i+1) ⊕ b(i+2) ⊕ b(i+3) (indices mod 4, GF(2^8) with polynomial 0x11B). Then the round subkey is XORed in.
- R4: The last encryption round applies only the S-box. The subkey presented at index `ROUNDS` has no effect in either direction.
- R5: In the 64-bit build, word 0 is bits [31:0] and word 1 is bits [63:32]. Every round starts by making word 0 = {w1[31:24], w0[23:16], w1[15:8], w0[7:0]} and word 1 = {w0[31:24], w1[23:16], w0[15:8], w1[7:0]}. For example, (w0, w1) = (0x00112233, 0xaabbccdd) becomes (0xaa11cc33, 0x00bb22dd).
- R6: Decryption is the exact inverse of encryption under the same subkeys, so decrypting a ciphertext returns the original plaintext.
- R7: During encryption, the k-th busy cycle (k = 1..ROUNDS) presents key index k. During decryption it presents index ROUNDS+1−k, so subkeys are used from ROUNDS−1 down to 1.
- R8: A `start` pulse, or a change of `encrypt` or `din`, while the core is busy has no effect on the running operation, its result or its latency.
- R9: After `done`, `dout` holds the result unchanged until the next accepted `start`.
- R10: The default round count is 19 for the 32-bit build and 15 for the 64-bit build.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, accepted only when idle |
| encrypt | input | 1 | 1 = encrypt, 0 = decrypt, sampled with `start` |
| din | input | BLOCK_W | Input block |
| key_idx | output | $clog2(ROUNDS+1) | Round index of the subkey wanted now |
| subkey | input | BLOCK_W | Subkey for `key_idx`, same cycle |
| dout | output | BLOCK_W | Result, valid from `done` onward |
| done | output | 1 | One-cycle completion pulse |

## Verification
A software model that derives the S-box from exponent and logarithm tables predicts every ciphertext and plaintext. A wrong column-mix coefficient, byte order or word-exchange lane therefore shows up as a mismatch on all vectors, and a missing exchange shows up in the 64-bit build. The bench corrupts the subkey at the last index. A core that still adds a key in its final encryption round, or in its first decryption step, then gives a different result. A second `start` is fired mid-run with inverted data and the opposite direction. A core that re-arms would finish late or return garbage. The bench also records the index sequence each cycle, which catches an off-by-one or an ascending order in decryption, and it watches `dout` after completion for drift.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic {
        DIR_DEC = 1'b0,
        DIR_ENC = 1'b1
    } dir_e;

    // one 32-bit column, element 0 is the least significant byte
    typedef logic [3:0][7:0] col_t;

    function automatic logic [7:0] gf_x2(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] p;
        acc = 8'h00;
        p   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ p;
            p = gf_x2(p);
        end
        return acc;
    endfunction

    // multiplicative inverse as a^254, zero maps to zero
    function automatic logic [7:0] gf_inv(input logic [7:0] a);
        logic [7:0] sq;
        logic [7:0] r;
        sq = a;
        r  = 8'h01;
        for (int i = 1; i < 8; i++) begin
            sq = gf_mul(sq, sq);
            r  = gf_mul(r, sq);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] a, input int k);
        logic [15:0] d;
        d = {a, a};
        return d[15-k -: 8];
    endfunction

    function automatic logic [7:0] sub_fwd(input logic [7:0] a);
        logic [7:0] v;
        v = gf_inv(a);
        return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
    endfunction

    function automatic logic [7:0] sub_rev(input logic [7:0] s);
        logic [7:0] v;
        v = rotl8(s, 1) ^ rotl8(s, 3) ^ rotl8(s, 6) ^ 8'h05;
        return gf_inv(v);
    endfunction

    function automatic col_t col_mix(input col_t a);
        col_t o;
        for (int i = 0; i < 4; i++) begin
            o[i] = gf_x2(a[i]) ^ gf_x2(a[(i+1)%4]) ^ a[(i+1)%4]
                 ^ a[(i+2)%4] ^ a[(i+3)%4];
        end
        return o;
    endfunction

    function automatic col_t col_unmix(input col_t a);
        col_t o;
        for (int i = 0; i < 4; i++) begin
            o[i] = gf_mul(a[i], 8'h0e) ^ gf_mul(a[(i+1)%4], 8'h0b)
                 ^ gf_mul(a[(i+2)%4], 8'h0d) ^ gf_mul(a[(i+3)%4], 8'h09);
        end
        return o;
    endfunction

    // trades the odd bytes between the two words; self-inverse
    function automatic logic [63:0] word_trade(input logic [63:0] s);
        logic [31:0] w0;
        logic [31:0] w1;
        w0 = s[31:0];
        w1 = s[63:32];
        return {w0[31:24], w1[23:16], w0[15:8], w1[7:0],
                w1[31:24], w0[23:16], w1[15:8], w0[7:0]};
    endfunction

endpackage

// File: rtl/sbc_column.sv
module sbc_column
    import sbc_pkg::*;
(
    input  col_t col_in,
    input  col_t key_col,
    input  logic encrypt,
    input  logic plain,
    output col_t col_out
);

    col_t subbed;
    col_t mixed;
    col_t unmixed;
    col_t pre_inv;

    always_comb begin
        for (int i = 0; i < 4; i++) subbed[i] = sub_fwd(col_in[i]);
        mixed   = col_mix(subbed);
        unmixed = col_unmix(col_in ^ key_col);
        pre_inv = plain ? col_in : unmixed;
        if (encrypt) begin
            col_out = plain ? subbed : (mixed ^ key_col);
        end else begin
            for (int i = 0; i < 4; i++) col_out[i] = sub_rev(pre_inv[i]);
        end
    end

endmodule

// File: rtl/sbc_round.sv
module sbc_round
    import sbc_pkg::*;
#(
    parameter int BLOCK_W = 32
) (
    input  logic [BLOCK_W-1:0] state_in,
    input  logic [BLOCK_W-1:0] subkey,
    input  logic               encrypt,
    input  logic               plain,
    output logic [BLOCK_W-1:0] state_out
);

    localparam int COLS = BLOCK_W / 32;

    logic [BLOCK_W-1:0] enc_src;
    logic [BLOCK_W-1:0] col_src;
    logic [BLOCK_W-1:0] col_res;
    logic [BLOCK_W-1:0] dec_res;

    generate
        if (COLS == 2) begin : g_trade
            assign enc_src = word_trade(state_in);
            assign dec_res = word_trade(col_res);
        end else begin : g_single
            assign enc_src = state_in;
            assign dec_res = col_res;
        end
    endgenerate

    assign col_src = encrypt ? enc_src : state_in;

    generate
        for (genvar k = 0; k < COLS; k++) begin : g_col
            sbc_column u_col (
                .col_in  (col_src[32*k +: 32]),
                .key_col (subkey[32*k +: 32]),
                .encrypt (encrypt),
                .plain   (plain),
                .col_out (col_res[32*k +: 32])
            );
        end
    endgenerate

    assign state_out = encrypt ? col_res : dec_res;

endmodule

// File: rtl/sbc_seq.sv
module sbc_seq
    import sbc_pkg::*;
#(
    parameter int ROUNDS = 19,
    parameter int CNT_W  = $clog2(ROUNDS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             encrypt,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output dir_e             dir,
    output logic             load,
    output logic             plain,
    output logic [CNT_W-1:0] key_idx,
    output logic             done
);

    localparam logic [CNT_W-1:0] LAST  = CNT_W'(ROUNDS);
    localparam logic [CNT_W-1:0] FIRST = CNT_W'(1);
    localparam logic [CNT_W-1:0] RPLUS = CNT_W'(ROUNDS + 1);

    assign load = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            dir  <= DIR_ENC;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy <= 1'b1;
                cnt  <= FIRST;
                dir  <= encrypt ? DIR_ENC : DIR_DEC;
            end else if (busy) begin
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + FIRST;
                end
            end
        end
    end

    always_comb begin
        if (dir == DIR_ENC) begin
            plain   = (cnt == LAST);
            key_idx = cnt;
        end else begin
            plain   = (cnt == FIRST);
            key_idx = RPLUS - cnt;
        end
    end

endmodule

// File: rtl/sbc_core.sv
module sbc_core
    import sbc_pkg::*;
#(
    parameter int BLOCK_W = 32,
    parameter int ROUNDS  = (BLOCK_W == 32) ? 19 : 15,
    parameter int CNT_W   = $clog2(ROUNDS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               encrypt,
    input  logic [BLOCK_W-1:0] din,
    output logic [CNT_W-1:0]   key_idx,
    input  logic [BLOCK_W-1:0] subkey,
    output logic [BLOCK_W-1:0] dout,
    output logic               done
);

    logic               busy;
    logic [CNT_W-1:0]   cnt;
    dir_e               dir;
    logic               load;
    logic               plain;
    logic [BLOCK_W-1:0] state_q;
    logic [BLOCK_W-1:0] next_state;

    sbc_seq #(
        .ROUNDS (ROUNDS),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .encrypt (encrypt),
        .busy    (busy),
        .cnt     (cnt),
        .dir     (dir),
        .load    (load),
        .plain   (plain),
        .key_idx (key_idx),
        .done    (done)
    );

    sbc_round #(
        .BLOCK_W (BLOCK_W)
    ) u_round (
        .state_in  (state_q),
        .subkey    (subkey),
        .encrypt   (dir == DIR_ENC),
        .plain     (plain),
        .state_out (next_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (load) begin
            state_q <= din;
        end else if (busy) begin
            state_q <= next_state;
        end
    end

    assign dout = state_q;

endmodule

// File: rtl/sbc_core_chk.sv
module sbc_core_chk #(
    parameter int BLOCK_W = 32,
    parameter int ROUNDS  = 19,
    parameter int CNT_W   = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic               done,
    input logic               busy,
    input logic [CNT_W-1:0]   cnt,
    input logic [CNT_W-1:0]   key_idx,
    input logic [BLOCK_W-1:0] dout
);

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (!done && !busy && dout == '0));

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && cnt == CNT_W'(1)));

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    finish_done_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == CNT_W'(ROUNDS)) |=> (done && !busy));

    // R8
    run_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != CNT_W'(ROUNDS)) |=> (busy && cnt == CNT_W'($past(cnt) + 1'b1)));

    // R7
    key_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (key_idx >= CNT_W'(1) && key_idx <= CNT_W'(ROUNDS)));

    // R9
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> (busy || $stable(dout)));

endmodule

bind sbc_core sbc_core_chk #(
    .BLOCK_W (BLOCK_W),
    .ROUNDS  (ROUNDS),
    .CNT_W   (CNT_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .done    (done),
    .busy    (busy),
    .cnt     (cnt),
    .key_idx (key_idx),
    .dout    (dout)
);

// File: tb/test_sbc_core.sv
module test_sbc_core;

    localparam int CLK_PERIOD = 10;
    localparam int N32 = 19;
    localparam int N64 = 15;
    localparam int NVEC = 8;

    localparam logic [63:0] VEC_DATA [NVEC] = '{
        64'h0000_0000_0000_0000, 64'hffff_ffff_ffff_ffff,
        64'h0123_4567_89ab_cdef, 64'h8000_0000_0000_0001,
        64'hdead_beef_cafe_f00d, 64'h5a5a_a5a5_3c3c_c3c3,
        64'h0000_0001_0000_0000, 64'h7f7f_7f7f_0101_0101};
    localparam logic [63:0] VEC_SEED [NVEC] = '{
        64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000,
        64'h1111_2222_3333_4444, 64'hffff_ffff_ffff_ffff,
        64'h0f1e_2d3c_4b5a_6978, 64'h9e37_79b9_7f4a_7c15,
        64'hc0de_d00d_1234_5678, 64'h0000_0001_8000_0000};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start32 = 1'b0;
    logic        start64 = 1'b0;
    logic        enc = 1'b1;
    logic [63:0] din = '0;
    logic [63:0] seed = '0;
    logic [63:0] tamper = '0;
    logic [4:0]  kidx32;
    logic [3:0]  kidx64;
    logic [63:0] k32full;
    logic [31:0] key32;
    logic [63:0] key64;
    logic [31:0] dout32;
    logic [63:0] dout64;
    logic        done32;
    logic        done64;

    int total = 0;
    int bad = 0;

    int exp_t [256];
    int log_t [256];
    logic [7:0] sb [256];
    logic [7:0] isb [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] kgen(input logic [63:0] s, input int idx);
        logic [31:0] i;
        i = 32'(idx);
        return {s[63:32] ^ (i * 32'h9e37_79b9), s[31:0] + i * 32'h7f4a_7c15};
    endfunction

    assign k32full = kgen(seed, int'(kidx32)) ^ ((int'(kidx32) == N32) ? tamper : 64'h0);
    assign key32   = k32full[31:0];
    assign key64   = kgen(seed, int'(kidx64)) ^ ((int'(kidx64) == N64) ? tamper : 64'h0);

    sbc_core #(.BLOCK_W(32)) i_sbc_core (
        .clk(clk), .rst(rst), .start(start32), .encrypt(enc), .din(din[31:0]),
        .key_idx(kidx32), .subkey(key32), .dout(dout32), .done(done32));

    sbc_core #(.BLOCK_W(64)) i_sbc_core_w64 (
        .clk(clk), .rst(rst), .start(start64), .encrypt(enc), .din(din),
        .key_idx(kidx64), .subkey(key64), .dout(dout64), .done(done64));

    // ---------------- reference model ----------------
    function automatic int gmul(input int a, input int b);
        if (a == 0 || b == 0) return 0;
        return exp_t[(log_t[a] + log_t[b]) % 255];
    endfunction

    task automatic build_tables();
        int e;
        logic [7:0] inv;
        logic [7:0] o;
        e = 1;
        for (int i = 0; i < 255; i++) begin
            exp_t[i] = e;
            log_t[e] = i;
            e = e ^ (((e << 1) ^ ((e & 8'h80) != 0 ? 8'h1b : 8'h00)) & 8'hff);
        end
        for (int a = 0; a < 256; a++) begin
            inv = (a == 0) ? 8'h00 : 8'(exp_t[(255 - log_t[a]) % 255]);
            for (int b = 0; b < 8; b++)
                o[b] = inv[b] ^ inv[(b+4)%8] ^ inv[(b+5)%8] ^ inv[(b+6)%8]
                     ^ inv[(b+7)%8] ^ ((8'h63 >> b) & 8'h01) != 0;
            sb[a] = o;
            isb[o] = 8'(a);
        end
    endtask

    function automatic logic [31:0] m_mix(input logic [31:0] w, input bit inverse);
        int cf [4];
        logic [31:0] r;
        int acc;
        if (inverse) cf = '{14, 11, 13, 9};
        else         cf = '{2, 3, 1, 1};
        for (int i = 0; i < 4; i++) begin
            acc = 0;
            for (int j = 0; j < 4; j++)
                acc = acc ^ gmul(cf[(j - i + 4) % 4], int'(w[8*j +: 8]));
            r[8*i +: 8] = 8'(acc);
        end
        return r;
    endfunction

    function automatic logic [63:0] m_swap(input logic [63:0] s);
        logic [63:0] r;
        r = s;
        r[31:24] = s[63:56]; r[63:56] = s[31:24];
        r[15:8]  = s[47:40]; r[47:40] = s[15:8];
        return r;
    endfunction

    function automatic logic [63:0] m_sub(input logic [63:0] s, input bit inverse);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[8*b +: 8] = inverse ? isb[s[8*b +: 8]] : sb[s[8*b +: 8]];
        return r;
    endfunction

    function automatic logic [63:0] m_enc(input logic [63:0] d, input bit w64, input logic [63:0] sd);
        int n;
        logic [63:0] s;
        logic [63:0] mask;
        n = w64 ? N64 : N32;
        mask = w64 ? 64'hffff_ffff_ffff_ffff : 64'h0000_0000_ffff_ffff;
        s = d & mask;
        for (int r = 1; r <= n; r++) begin
            if (w64) s = m_swap(s);
            s = m_sub(s, 1'b0) & mask;
            if (r < n) begin
                s = {m_mix(s[63:32], 1'b0), m_mix(s[31:0], 1'b0)} & mask;
                s = s ^ (kgen(sd, r) & mask);
            end
        end
        return s;
    endfunction

    function automatic logic [63:0] m_dec(input logic [63:0] d, input bit w64, input logic [63:0] sd);
        int n;
        logic [63:0] s;
        logic [63:0] mask;
        n = w64 ? N64 : N32;
        mask = w64 ? 64'hffff_ffff_ffff_ffff : 64'h0000_0000_ffff_ffff;
        s = d & mask;
        for (int st = 1; st <= n; st++) begin
            if (st > 1) begin
                s = s ^ (kgen(sd, n + 1 - st) & mask);
                s = {m_mix(s[63:32], 1'b1), m_mix(s[31:0], 1'b1)} & mask;
            end
            s = m_sub(s, 1'b1) & mask;
            if (w64) s = m_swap(s);
        end
        return s;
    endfunction

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    task automatic run_op(input bit w64, input bit e, input logic [63:0] d, input bit poke,
                          output logic [63:0] res, output int lat, output int idx_bad,
                          output bit tail_low);
        int n;
        int expi;
        int goti;
        n = w64 ? N64 : N32;
        @(negedge clk);
        enc = e;
        din = d;
        if (w64) start64 = 1'b1; else start32 = 1'b1;
        @(negedge clk);
        start32 = 1'b0;
        start64 = 1'b0;
        lat = 0;
        idx_bad = 0;
        while (!(w64 ? done64 : done32) && lat < 100) begin
            expi = e ? lat + 1 : n - lat;
            goti = w64 ? int'(kidx64) : int'(kidx32);
            if (goti != expi) idx_bad++;
            if (poke && lat == 2) begin
                din = ~d;
                enc = ~e;
                if (w64) start64 = 1'b1; else start32 = 1'b1;
            end
            @(negedge clk);
            start32 = 1'b0;
            start64 = 1'b0;
            enc = e;
            din = d;
            lat++;
        end
        res = w64 ? dout64 : {32'h0, dout32};
        @(negedge clk);
        tail_low = w64 ? !done64 : !done32;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog R2 act=hung exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] res;
        logic [63:0] res2;
        logic [63:0] expv;
        int lat;
        int ib;
        bit tl;
        int n;

        build_tables();
        // R3: model sanity against known constants
        chk(sb[8'h00] == 8'h63 && sb[8'h53] == 8'hed, "R3 model sbox", {48'h0, sb[8'h00], sb[8'h53]}, 64'h63ed);
        chk(m_mix(32'h4553_13db, 1'b0) == 32'hbca1_4d8e, "R3 model mix", {32'h0, m_mix(32'h4553_13db, 1'b0)}, 64'hbca1_4d8e);
        // R5: byte exchange example
        chk(m_swap(64'haabbccdd_00112233) == 64'h00bb22dd_aa11cc33, "R5 model exchange",
            m_swap(64'haabbccdd_00112233), 64'h00bb22dd_aa11cc33);

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!done32 && !done64, "R1 done low in reset", {62'h0, done64, done32}, 64'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(dout32 == 32'h0 && dout64 == 64'h0 && !done32 && !done64, "R1 idle after reset",
            dout64 | {32'h0, dout32}, 64'h0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            for (int w = 0; w < 2; w++) begin
                n = (w == 1) ? N64 : N32;
                seed = VEC_SEED[i];
                expv = m_enc(VEC_DATA[i], w == 1, seed);
                run_op(w == 1, 1'b1, VEC_DATA[i], 1'b0, res, lat, ib, tl);
                chk(res == expv, (w == 1) ? "R3/R4/R5 encrypt w64" : "R3/R4 encrypt w32", res, expv);
                chk(lat == n && tl, "R2 latency and pulse", 64'(lat), 64'(n));
                chk(ib == 0, "R7 key index order enc", 64'(ib), 64'h0);
                run_op(w == 1, 1'b0, res, 1'b0, res2, lat, ib, tl);
                expv = (w == 1) ? VEC_DATA[i] : {32'h0, VEC_DATA[i][31:0]};
                chk(res2 == expv, "R6 decrypt round trip", res2, expv);
                chk(ib == 0, "R7 key index order dec", 64'(ib), 64'h0);
                expv = m_dec(VEC_DATA[i], w == 1, seed);
                run_op(w == 1, 1'b0, VEC_DATA[i], 1'b0, res, lat, ib, tl);
                chk(res == expv, "R6 decrypt vs model", res, expv);
            end
        end

        // R10: default round counts visible as latency
        seed = 64'h2468_ace0_1357_9bdf;
        run_op(1'b0, 1'b1, 64'h1234, 1'b0, res, lat, ib, tl);
        chk(lat == 19, "R10 rounds w32", 64'(lat), 64'd19);
        run_op(1'b1, 1'b1, 64'h1234, 1'b0, res, lat, ib, tl);
        chk(lat == 15, "R10 rounds w64", 64'(lat), 64'd15);

        // R4: subkey at last index has no effect
        for (int w = 0; w < 2; w++) begin
            tamper = '0;
            run_op(w == 1, 1'b1, 64'hfeed_face_0bad_f00d, 1'b0, res, lat, ib, tl);
            tamper = 64'hffff_ffff_ffff_ffff;
            run_op(w == 1, 1'b1, 64'hfeed_face_0bad_f00d, 1'b0, res2, lat, ib, tl);
            chk(res == res2, "R4 last enc key ignored", res2, res);
            tamper = '0;
            run_op(w == 1, 1'b0, 64'h0bad_cafe_1234_5678, 1'b0, res, lat, ib, tl);
            tamper = 64'h5555_aaaa_5555_aaaa;
            run_op(w == 1, 1'b0, 64'h0bad_cafe_1234_5678, 1'b0, res2, lat, ib, tl);
            chk(res == res2, "R4 first dec key ignored", res2, res);
            tamper = '0;
        end

        // R8: start while busy ignored
        for (int w = 0; w < 2; w++) begin
            n = (w == 1) ? N64 : N32;
            seed = 64'h0102_0304_0506_0708;
            expv = m_enc(64'h89ab_cdef_0123_4567, w == 1, seed);
            run_op(w == 1, 1'b1, 64'h89ab_cdef_0123_4567, 1'b1, res, lat, ib, tl);
            chk(res == expv, "R8 busy start result", res, expv);
            chk(lat == n && tl, "R8 busy start latency", 64'(lat), 64'(n));
            // R9: result holds after done
            repeat (6) @(negedge clk);
            res2 = (w == 1) ? dout64 : {32'h0, dout32};
            chk(res2 == expv, "R9 result held", res2, expv);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule